// File: doc/BRIEF.md
# Halfword-to-Word Burst Write Packer

This block turns a stream of 16-bit halfwords into full-width 32-bit write bursts on an AXI4 write port (AW, W and B channels). A command gives a starting byte address and the number of halfwords that follow. Each pair of consecutive halfwords is joined into one 32-bit beat and placed in a small internal buffer. A burst is launched only once every beat it will carry is already in the buffer, so the data channel never stalls halfway through a burst.

Every burst uses the 4-byte transfer size and the incrementing burst type. Narrow transfers are never used. A start address that sits on a 2-byte boundary but not on a 4-byte one is handled with byte strobes: the first halfword lands in the upper half of the first beat. An odd total leaves a lone halfword, which goes in the lower half of the last beat. Each burst length is limited by a parameter, by the beats still to send, and by the distance to the next 4 KB page. Only one burst is outstanding at a time. An error response sets a flag that stays set until the next command, and a one-cycle pulse marks the end of the transfer.

Top module: `hw_axi_packer`

## Requirements
- R1: `cmd_ready` is 1 whenever the block is idle, including straight after reset, and drops to 0 the cycle after a non-empty command is accepted; `in_ready` is 0 while no transfer is active.
- R2: A beat whose byte address is covered by two halfwords of the transfer carries the earlier halfword in bits 15:0, the later one in bits 31:16, and strobe 4'b1111.
- R3: When address bit 1 of the start address is 1, the first beat is written at the start address with bits 1:0 cleared, carries the first halfword in bits 31:16 and has strobe 4'b1100.
- R4: When the transfer ends on a lone halfword, the last beat carries it in bits 15:0 with strobe 4'b0011.
- R5: Every address request carries size code 3'd2 (4 bytes per beat) and burst type 2'b01 (incrementing).
- R6: Bursts follow one another at consecutive word addresses, and each has length min(MAX_BURST, beats left, words to the next 4 KB boundary), with the length field equal to beats minus one.
- R7: A burst's address request is raised only after every halfword that the burst carries has been accepted on the input, and the buffer never overflows.
- R8: Once raised, the address request stays valid with stable address and length until accepted.
- R9: `wlast` is 1 on the final beat of each burst and on no other beat.
- R10: No new address request is raised while a burst is still waiting for its write response.
- R11: A write response other than 2'b00 sets `err`. It stays set until the next command is accepted, and that acceptance clears it.
- R12: `done` is a one-cycle pulse in the cycle after the last write response of a transfer is accepted. A command with a count of 0 is accepted, issues no burst, and gives the pulse in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address, 2-byte aligned |
| cmd_count | input | COUNT_W | Number of halfwords in the transfer |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword can be taken |
| in_data | input | 16 | Halfword data |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Transfer size code |
| awburst | output | 2 | Burst type |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Address request accepted |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Byte strobes |
| wlast | output | 1 | Final beat of burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response accepted |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Error response seen in this transfer |

## Verification
An accepted halfword completes a beat in the buffer at that same edge. A burst's address request appears at the earliest two edges after its last beat enters the buffer. `done` and `err` change at the edge that takes the final or failing response, and `cmd_ready` drops at the edge that accepts the command. The bench drives inputs and the slave's ready signals at falling edges and reads every output at falling edges. At each falling edge it marks which handshakes will complete at the next rising edge. It then expects each registered effect at the falling edge that follows that rising edge. This keeps every comparison one half-cycle away from the edge that produces it.

// File: rtl/hwpk_pkg.sv
package hwpk_pkg;

  localparam int HW_W   = 16;
  localparam int WORD_W = 32;
  localparam int STRB_W = 4;

  localparam logic [STRB_W-1:0] STRB_FULL  = 4'b1111;
  localparam logic [STRB_W-1:0] STRB_UPPER = 4'b1100;
  localparam logic [STRB_W-1:0] STRB_LOWER = 4'b0011;

  localparam logic [2:0] SIZE_WORD  = 3'd2;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  typedef struct packed {
    logic [STRB_W-1:0] strb;
    logic [WORD_W-1:0] data;
  } beat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } ctl_state_e;

  // Beats needed for hw halfwords when the first one may sit in the upper lane.
  function automatic int unsigned beats_for(logic odd, int unsigned hw);
    if (hw == 0) return 0;
    return (hw + (odd ? 32'd1 : 32'd0) + 32'd1) >> 1;
  endfunction

  // Whole words left before the next 4 KB page boundary.
  function automatic int unsigned words_to_page(logic [11:0] lo);
    return (32'd4096 - {20'd0, lo}) >> 2;
  endfunction

  // Length of the next burst: smallest of what is left, page room and the cap.
  function automatic int unsigned burst_len(int unsigned left, int unsigned room,
                                            int unsigned cap);
    int unsigned n;
    n = left;
    if (room < n) n = room;
    if (cap < n) n = cap;
    return n;
  endfunction

endpackage

// File: rtl/hwpk_packer.sv
module hwpk_packer
  import hwpk_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_odd,
  input  logic [COUNT_W-1:0] start_count,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [HW_W-1:0]    in_data,
  input  logic               buf_full,
  output logic               push,
  output beat_t              push_beat
);

  logic               active;
  logic               lane_hi;
  logic               have_lo;
  logic [HW_W-1:0]    lo_q;
  logic [COUNT_W-1:0] left;

  logic take;
  logic last_hw;

  assign in_ready = active && !buf_full;
  assign take     = in_valid && in_ready;
  assign last_hw  = (left == COUNT_W'(1));
  assign push     = take && (lane_hi || last_hw);

  always_comb begin
    if (lane_hi) begin
      push_beat.data = {in_data, (have_lo ? lo_q : {HW_W{1'b0}})};
      push_beat.strb = have_lo ? STRB_FULL : STRB_UPPER;
    end else begin
      push_beat.data = {{HW_W{1'b0}}, in_data};
      push_beat.strb = STRB_LOWER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lane_hi <= 1'b0;
      have_lo <= 1'b0;
      lo_q    <= '0;
      left    <= '0;
    end else if (start) begin
      active  <= (start_count != '0);
      lane_hi <= start_odd;
      have_lo <= 1'b0;
      left    <= start_count;
    end else if (take) begin
      left <= left - COUNT_W'(1);
      if (last_hw) active <= 1'b0;
      if (lane_hi) begin
        lane_hi <= 1'b0;
        have_lo <= 1'b0;
      end else begin
        lane_hi <= 1'b1;
        have_lo <= 1'b1;
        lo_q    <= in_data;
      end
    end
  end

endmodule

// File: rtl/hwpk_fifo.sv
module hwpk_fifo
  import hwpk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  beat_t            din,
  input  logic             pop,
  output beat_t            dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  beat_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/hwpk_burst_ctl.sv
module hwpk_burst_ctl
  import hwpk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BEAT_W    = 17,
  parameter int MAX_BURST = 16,
  parameter int CNT_W     = 5,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [BEAT_W-1:0] start_beats,
  output logic              idle,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic              buf_empty,
  input  beat_t             buf_head,
  output logic              pop,
  output logic [ADDR_W-1:0] awaddr,
  output logic [7:0]        awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              awvalid,
  input  logic              awready,
  output logic [WORD_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready,
  output logic              done,
  output logic              err
);

  ctl_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [BEAT_W-1:0] beats_left;
  logic [LEN_W-1:0]  cur_len;
  logic [LEN_W-1:0]  beat_idx;
  logic [LEN_W-1:0]  next_len;
  logic              fill_ok;
  logic              last_resp;

  assign next_len = LEN_W'(burst_len(32'(beats_left), words_to_page(cur_addr[11:0]),
                                     MAX_BURST));
  assign fill_ok  = (32'(buf_count) >= 32'(next_len));
  assign last_resp = (beats_left == BEAT_W'(cur_len));

  assign idle    = (state == ST_IDLE);
  assign awaddr  = cur_addr;
  assign awlen   = 8'(cur_len) - 8'd1;
  assign awsize  = SIZE_WORD;
  assign awburst = BURST_INCR;
  assign awvalid = (state == ST_ADDR);
  assign wvalid  = (state == ST_DATA) && !buf_empty;
  assign wdata   = buf_head.data;
  assign wstrb   = buf_head.strb;
  assign wlast   = (beat_idx == cur_len - LEN_W'(1));
  assign pop     = wvalid && wready;
  assign bready  = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      beats_left <= '0;
      cur_len    <= '0;
      beat_idx   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            err        <= 1'b0;
            cur_addr   <= start_addr & ~ADDR_W'(3);
            beats_left <= start_beats;
            if (start_beats == '0) done  <= 1'b1;
            else                   state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (fill_ok) begin
            cur_len <= next_len;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (awready) begin
            beat_idx <= '0;
            state    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (pop) begin
            beat_idx <= beat_idx + LEN_W'(1);
            if (wlast) state <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (bvalid) begin
            if (bresp != RESP_OKAY) err <= 1'b1;
            beats_left <= beats_left - BEAT_W'(cur_len);
            cur_addr   <= cur_addr + ADDR_W'({cur_len, 2'b00});
            if (last_resp) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hw_axi_packer.sv
module hw_axi_packer
  import hwpk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int COUNT_W    = 16,
  parameter int MAX_BURST  = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [COUNT_W-1:0] cmd_count,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [15:0]        in_data,
  output logic [ADDR_W-1:0]  awaddr,
  output logic [7:0]         awlen,
  output logic [2:0]         awsize,
  output logic [1:0]         awburst,
  output logic               awvalid,
  input  logic               awready,
  output logic [31:0]        wdata,
  output logic [3:0]         wstrb,
  output logic               wlast,
  output logic               wvalid,
  input  logic               wready,
  input  logic [1:0]         bresp,
  input  logic               bvalid,
  output logic               bready,
  output logic               done,
  output logic               err
);

  localparam int BEAT_W    = COUNT_W + 1;
  localparam int BUF_DEPTH = (FIFO_DEPTH < MAX_BURST) ? MAX_BURST : FIFO_DEPTH;
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic              start;
  logic              pk_push;
  beat_t             pk_beat;
  logic              buf_pop;
  beat_t             buf_head;
  logic [CNT_W-1:0]  buf_count;
  logic              buf_full;
  logic              buf_empty;
  logic              ctl_idle;
  logic [BEAT_W-1:0] start_beats;

  assign cmd_ready   = ctl_idle;
  assign start       = cmd_valid && cmd_ready;
  assign start_beats = BEAT_W'(beats_for(cmd_addr[1], 32'(cmd_count)));

  hwpk_packer #(
    .COUNT_W (COUNT_W)
  ) u_packer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_odd   (cmd_addr[1]),
    .start_count (cmd_count),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .buf_full    (buf_full),
    .push        (pk_push),
    .push_beat   (pk_beat)
  );

  hwpk_fifo #(
    .DEPTH (BUF_DEPTH),
    .CNT_W (CNT_W)
  ) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (pk_push),
    .din   (pk_beat),
    .pop   (buf_pop),
    .dout  (buf_head),
    .count (buf_count),
    .full  (buf_full),
    .empty (buf_empty)
  );

  hwpk_burst_ctl #(
    .ADDR_W    (ADDR_W),
    .BEAT_W    (BEAT_W),
    .MAX_BURST (MAX_BURST),
    .CNT_W     (CNT_W)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (cmd_addr),
    .start_beats (start_beats),
    .idle        (ctl_idle),
    .buf_count   (buf_count),
    .buf_empty   (buf_empty),
    .buf_head    (buf_head),
    .pop         (buf_pop),
    .awaddr      (awaddr),
    .awlen       (awlen),
    .awsize      (awsize),
    .awburst     (awburst),
    .awvalid     (awvalid),
    .awready     (awready),
    .wdata       (wdata),
    .wstrb       (wstrb),
    .wlast       (wlast),
    .wvalid      (wvalid),
    .wready      (wready),
    .bresp       (bresp),
    .bvalid      (bvalid),
    .bready      (bready),
    .done        (done),
    .err         (err)
  );

endmodule

// File: rtl/hw_axi_packer_chk.sv
module hw_axi_packer_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16,
  parameter int BUF_DEPTH = 16,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] awaddr,
  input logic [7:0]        awlen,
  input logic [2:0]        awsize,
  input logic [1:0]        awburst,
  input logic              awvalid,
  input logic              awready,
  input logic [3:0]        wstrb,
  input logic              wlast,
  input logic              wvalid,
  input logic              wready,
  input logic [1:0]        bresp,
  input logic              bvalid,
  input logic              bready,
  input logic              done,
  input logic              err,
  input logic              pk_push,
  input logic              buf_pop,
  input logic [CNT_W-1:0]  buf_count
);

  logic       outstanding;
  logic [7:0] len_q;
  logic [7:0] beat_cnt;
  logic       aw_fire;
  logic       w_fire;
  logic       b_fire;

  assign aw_fire = awvalid && awready;
  assign w_fire  = wvalid && wready;
  assign b_fire  = bvalid && bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      len_q       <= '0;
      beat_cnt    <= '0;
    end else begin
      if (aw_fire) begin
        outstanding <= 1'b1;
        len_q       <= awlen;
        beat_cnt    <= '0;
      end else if (b_fire) begin
        outstanding <= 1'b0;
      end
      if (w_fire) beat_cnt <= beat_cnt + 8'd1;
    end
  end

  assert_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awsize == 3'd2) && (awburst == 2'b01));

  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (32'(awlen) < MAX_BURST));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_push && !buf_pop) |-> (32'(buf_count) < BUF_DEPTH));

  assert_aw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid && $stable(awaddr) && $stable(awlen));

  assert_strobe_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wstrb == 4'b1111) || (wstrb == 4'b1100) || (wstrb == 4'b0011));

  assert_wlast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |-> (wlast == (beat_cnt == len_q)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> !outstanding);

  assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(b_fire && (bresp != 2'b00)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind hw_axi_packer hw_axi_packer_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_BURST (MAX_BURST),
  .BUF_DEPTH (BUF_DEPTH),
  .CNT_W     (CNT_W)
) i_chk (.*);

// File: tb/test_hw_axi_packer.sv
module test_hw_axi_packer;

  localparam int ADDR_W  = 32;
  localparam int COUNT_W = 16;
  localparam int MAXB    = 4;
  localparam int DEPTH   = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [ADDR_W-1:0]  cmd_addr = '0;
  logic [COUNT_W-1:0] cmd_count = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [15:0]        in_data = '0;
  logic [ADDR_W-1:0]  awaddr;
  logic [7:0]         awlen;
  logic [2:0]         awsize;
  logic [1:0]         awburst;
  logic               awvalid;
  logic               awready = 1'b0;
  logic [31:0]        wdata;
  logic [3:0]         wstrb;
  logic               wlast;
  logic               wvalid;
  logic               wready = 1'b0;
  logic [1:0]         bresp = 2'b00;
  logic               bvalid = 1'b0;
  logic               bready;
  logic               done;
  logic               err;

  always #4 clk = ~clk;

  hw_axi_packer #(
    .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .MAX_BURST(MAXB), .FIFO_DEPTH(DEPTH)
  ) i_hw_axi_packer (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .done(done), .err(err)
  );

  typedef struct {
    logic [31:0] data;
    logic [3:0]  strb;
    bit          last;
    string       tag;
  } exp_beat_t;

  typedef struct {
    logic [31:0] addr;
    int          len;
  } exp_aw_t;

  exp_beat_t   beat_q[$];
  exp_aw_t     aw_q[$];
  logic [1:0]  resp_q[$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Shared scenario state (written by the driver between transfers).
  bit  stall_en  = 1'b0;
  bit  zero_mode = 1'b0;
  int  x_off = 0;
  int  x_count = 0;
  int  x_beats_before = 0;
  int  x_bursts_left = 0;
  int  hw_acc = 0;
  int  done_cnt = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // ---------------- slave model and monitor ----------------
  logic [7:0] lfsr = 8'h5a;
  bit   aw_seen = 1'b0;
  bit   outstanding = 1'b0;
  bit   b_pend = 1'b0;
  bit   b_took = 1'b0;
  bit   exp_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      awready = stall_en ? lfsr[0] : 1'b1;
      wready  = stall_en ? lfsr[2] : 1'b1;

      // done must appear exactly one cycle after the final response edge.
      if (done) done_cnt++;
      if (!zero_mode)
        check(done == exp_done, "R12", "done pulse timing", 64'(done), 64'(exp_done));

      // B channel: drop after a handshake, raise for a pending response.
      if (b_took) begin
        bvalid = 1'b0;
        outstanding = 1'b0;
        x_bursts_left--;
      end
      if (b_pend && !bvalid) begin
        bvalid = 1'b1;
        b_pend = 1'b0;
        bresp = (resp_q.size() != 0) ? resp_q.pop_front() : 2'b00;
      end
      b_took   = bvalid && bready;
      exp_done = b_took && (x_bursts_left == 1);

      // AW channel.
      if (awvalid) begin
        if (outstanding)
          check(1'b0, "R10", "address raised with response pending", 64'(1), 64'(0));
        if (!aw_seen) begin
          aw_seen = 1'b1;
          if (aw_q.size() != 0) begin
            int need;
            need = 2 * (x_beats_before + aw_q[0].len) - x_off;
            if (need > x_count) need = x_count;
            check(hw_acc >= need, "R7", "halfwords accepted before burst",
                  64'(hw_acc), 64'(need));
          end
        end
        if (awready) begin
          aw_seen = 1'b0;
          outstanding = 1'b1;
          if (aw_q.size() == 0) begin
            check(1'b0, "R6", "unexpected burst", 64'(awaddr), 64'(0));
          end else begin
            exp_aw_t e;
            e = aw_q.pop_front();
            check(awaddr == e.addr, "R6", "burst address", 64'(awaddr), 64'(e.addr));
            check(32'(awlen) == e.len - 1, "R6", "burst length field",
                  64'(awlen), 64'(e.len - 1));
            check(awsize == 3'd2 && awburst == 2'b01, "R5", "size and type",
                  64'({awsize, awburst}), 64'({3'd2, 2'b01}));
            x_beats_before += e.len;
          end
        end
      end

      // W channel.
      if (wvalid && wready) begin
        if (beat_q.size() == 0) begin
          check(1'b0, "R2", "unexpected beat", 64'(wdata), 64'(0));
        end else begin
          exp_beat_t e;
          logic [31:0] m;
          e = beat_q.pop_front();
          m = {{8{e.strb[3]}}, {8{e.strb[2]}}, {8{e.strb[1]}}, {8{e.strb[0]}}};
          check(wstrb == e.strb, e.tag, "beat strobe", 64'(wstrb), 64'(e.strb));
          check((wdata & m) == (e.data & m), e.tag, "beat data",
                64'(wdata & m), 64'(e.data & m));
          check(wlast == e.last, "R9", "last flag", 64'(wlast), 64'(e.last));
          if (wlast) b_pend = 1'b1;
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic plan_xfer(int id, logic [31:0] addr, int count, int err_burst);
    int off, beats, cur, left, b;
    logic [31:0] ca;
    off = addr[1] ? 1 : 0;
    beats = (count == 0) ? 0 : (count + off + 1) / 2;
    // Beats with strobes from the requirements.
    for (int i = 0; i < beats; i++) begin
      exp_beat_t e;
      int k0, k1;
      k0 = 2 * i - off;
      k1 = 2 * i + 1 - off;
      e.data = '0;
      e.strb = '0;
      e.last = 1'b0;
      if (k0 >= 0 && k0 < count) begin
        e.strb[1:0] = 2'b11;
        e.data[15:0] = {id[3:0], 12'(k0)};
      end
      if (k1 >= 0 && k1 < count) begin
        e.strb[3:2] = 2'b11;
        e.data[31:16] = {id[3:0], 12'(k1)};
      end
      if (e.strb == 4'b1100) e.tag = "R3";
      else if (e.strb == 4'b0011) e.tag = "R4";
      else e.tag = "R2";
      beat_q.push_back(e);
    end
    // Burst split: cap, remaining beats, 4 KB page room.
    ca = addr & ~32'd3;
    left = beats;
    cur = beat_q.size() - beats;
    b = 0;
    while (left > 0) begin
      exp_aw_t a;
      int room, n;
      room = (4096 - int'(ca[11:0])) / 4;
      n = left;
      if (room < n) n = room;
      if (MAXB < n) n = MAXB;
      a.addr = ca;
      a.len = n;
      aw_q.push_back(a);
      resp_q.push_back((b == err_burst) ? 2'b10 : 2'b00);
      cur += n;
      beat_q[cur - 1].last = 1'b1;
      ca += 32'(4 * n);
      left -= n;
      b++;
    end
    x_bursts_left = b;
  endtask

  task automatic run_xfer(int id, logic [31:0] addr, int count, int gap, bit stall,
                          int err_burst);
    int dc;
    plan_xfer(id, addr, count, err_burst);
    stall_en = stall;
    x_off = addr[1] ? 1 : 0;
    x_count = count;
    x_beats_before = 0;
    hw_acc = 0;
    zero_mode = (count == 0);
    dc = done_cnt;
    cmd_valid = 1'b1;
    cmd_addr = addr;
    cmd_count = COUNT_W'(count);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (count == 0) begin
      check(done == 1'b1, "R12", "done after empty command", 64'(done), 64'(1));
      check(awvalid == 1'b0, "R12", "no burst for empty command", 64'(awvalid), 64'(0));
      @(negedge clk);
      zero_mode = 1'b0;
      return;
    end
    check(cmd_ready == 1'b0, "R1", "cmd_ready while busy", 64'(cmd_ready), 64'(0));
    for (int i = 0; i < count; i++) begin
      in_valid = 1'b1;
      in_data = {id[3:0], 12'(i)};
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      hw_acc++;
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
    while (done_cnt == dc) @(negedge clk);
    check(err == (err_burst >= 0), "R11", "error flag after transfer",
          64'(err), 64'(err_burst >= 0));
    check(beat_q.size() == 0 && aw_q.size() == 0, "R6", "all bursts and beats seen",
          64'(beat_q.size() + aw_q.size()), 64'(0));
    check(cmd_ready == 1'b1, "R1", "cmd_ready when idle again", 64'(cmd_ready), 64'(1));
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 64'(cmd_ready), 64'(1));
    check(in_ready == 1'b0, "R1", "in_ready while idle", 64'(in_ready), 64'(0));
    check(awvalid == 1'b0 && wvalid == 1'b0, "R1", "no traffic after reset",
          64'({awvalid, wvalid}), 64'(0));
    check(done == 1'b0 && err == 1'b0, "R12", "status after reset",
          64'({done, err}), 64'(0));

    // Aligned start, whole words, one burst (R2).
    run_xfer(1, 32'h0000_0100, 8, 0, 1'b0, -1);
    // Halfword-aligned start, first beat upper lane (R3).
    run_xfer(2, 32'h0000_0202, 7, 0, 1'b1, -1);
    // Lone final halfword in lower lane (R4).
    run_xfer(3, 32'h0000_0300, 5, 1, 1'b0, -1);
    // 4 KB page clamp and cap split (R6): 10 beats as 2, 4, 4.
    run_xfer(4, 32'h0000_0FF8, 20, 0, 1'b1, -1);
    // Odd start with a lone end, slow input and stalls (R3, R4, R7).
    run_xfer(5, 32'h0000_0502, 2, 3, 1'b1, -1);
    // Single halfword at odd start.
    run_xfer(6, 32'h0000_0602, 1, 0, 1'b0, -1);
    // Error response on the second burst (R11).
    run_xfer(7, 32'h0000_0700, 16, 0, 1'b1, 1);
    // Empty command clears the error and pulses done (R11, R12).
    run_xfer(8, 32'h0000_0800, 0, 0, 1'b0, -1);
    check(err == 1'b0, "R11", "error cleared by new command", 64'(err), 64'(0));
    // Long odd transfer with stalls.
    run_xfer(9, 32'h0000_1006, 23, 0, 1'b1, -1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule